// File: doc/BRIEF.md
# Synchronous SRAM Data Path with Selectable Output Latency

This block is a synthesizable model of the data path of a synchronous static RAM. On each rising clock edge it samples an address, a chip select and a set of write controls. It decodes them into a read, a write or a deselect. Writes go into a byte-lane storage array in the same edge. Reads come back either in the cycle after the sampling edge (flow-through) or one edge later through an output register (pipelined), as a static select input chooses.

The output side behaves like a tri-state driver and is shown as a data bus plus a drive flag. Turning the driver off after a deselect follows the same pipeline as a read. In addition, the driver stays on for one more cycle in flow-through mode, so that in both modes it switches off only after the second rising edge that follows the deselect. Output enable and the sleep input act without a clock. Sleep also blocks every command, and the stored contents stay intact.

Top module: `ssram_core`

## Requirements
- R1: While reset is asserted and right after it is released, `rdata_vld` is 0 and `rdata` is all zeros.
- R2: With `pipe_sel` = 0 (flow-through), a read sampled at edge k presents the word at its address on `rdata`, with `rdata_vld` = 1, from edge k until edge k+1.
- R3: With `pipe_sel` = 1 (pipelined), a read sampled at edge k presents its word from edge k+1 until edge k+2.
- R4: A command with `cs` = 1 and `gwr` = 1 writes every lane of `wdata` to `addr`, whatever `bwe` and `lane_en` are.
- R5: With `gwr` = 0, a command with `bwe` = 1 writes only the lanes whose `lane_en` bit is 1. Lane i occupies bits [LANE_W*i+LANE_W-1 : LANE_W*i], and the top bit of each 9-bit lane is stored like any other bit. A command with `bwe` = 0 or with `lane_en` all zero is a read.
- R6: When a deselect (`cs` = 0) is sampled at edge k and the command at edge k-1 was a read, the output stays driven with that read's word until edge k+1 and is released after it. This holds in both modes.
- R7: A write command does not drive the output in its result slot: after edge k in flow-through mode, after edge k+1 in pipelined mode.
- R8: `oe` = 0 forces `rdata_vld` to 0 and `rdata` to zero at once, without waiting for a clock. When `oe` returns to 1, the pending output comes back.
- R9: `sleep` = 1 forces the output off at once. Commands sampled while it is high are ignored, so no write reaches the array, and the stored data is unchanged afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control and output registers |
| pipe_sel | input | 1 | 1 = pipelined output, 0 = flow-through (static strap) |
| cs | input | 1 | Chip select; 0 samples a deselect |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data, lane i in bits [LANE_W*i +: LANE_W] |
| gwr | input | 1 | Global write: write all lanes |
| bwe | input | 1 | Byte-write enable, qualifies `lane_en` |
| lane_en | input | LANES | Per-lane write selects |
| oe | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Asynchronous sleep; blocks commands, disables output |
| rdata | output | LANES*LANE_W | Read data, zero while not driven |
| rdata_vld | output | 1 | Output driver enable |

## Verification
The hardest state to reach from the ports is the extra hold cycle after a deselect in flow-through mode. It shows only when a read is followed at once by `cs` = 0 while `oe` is high and `sleep` is low, and its data must come from the captured word rather than the live array output. Directed read-deselect-deselect runs in both modes force this state, and explicit checks cover the cycles on both sides of the release. A long random run, with deselect, sleep and `oe`-low each appearing often, then lands in it many times. In that run a cycle-level reference model computes the expected bus on every cycle. Short sub-cycle pulses on `oe` and `sleep` between clock edges show that both act without a clock.

// File: rtl/ssram_pkg.sv
`timescale 1ns/1ps
package ssram_pkg;
   typedef enum logic [1:0] {
      CMD_DESEL = 2'd0,
      CMD_READ  = 2'd1,
      CMD_WRITE = 2'd2
   } cmd_e;
endpackage

// File: rtl/ssram_wr_decode.sv
`timescale 1ns/1ps
module ssram_wr_decode
   import ssram_pkg::*;
#(
   parameter int LANES = 2
) (
   input  logic             cs,
   input  logic             sleep,
   input  logic             gwr,
   input  logic             bwe,
   input  logic [LANES-1:0] lane_en,
   output cmd_e             cmd,
   output logic [LANES-1:0] wr_mask
);
   logic accept;
   logic any_lane;
   logic byte_hit;

   assign accept   = cs & ~sleep;
   assign any_lane = |lane_en;
   assign byte_hit = bwe & any_lane;

   always_comb begin
      cmd     = CMD_DESEL;
      wr_mask = '0;
      if (accept) begin
         if (gwr) begin
            cmd     = CMD_WRITE;
            wr_mask = '1;
         end else if (byte_hit) begin
            cmd     = CMD_WRITE;
            wr_mask = lane_en;
         end else begin
            cmd = CMD_READ;
         end
      end
   end
endmodule

// File: rtl/ssram_array.sv
`timescale 1ns/1ps
module ssram_array #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 2,
   parameter int LANE_W = 9,
   localparam int DW    = LANES * LANE_W,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sleep_i,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DW-1:0]     wr_data,
   input  logic [LANES-1:0]  wr_mask,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DW-1:0]     rd_data
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] bank [DEPTH];

      always_ff @(posedge clk) begin
         if (wr_mask[g]) bank[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
      end

      assign rd_data[g*LANE_W +: LANE_W] = bank[rd_addr];
   end

   // R9
   sleep_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_i |-> (wr_mask == '0));
endmodule

// File: rtl/ssram_out_stage.sv
`timescale 1ns/1ps
module ssram_out_stage
   import ssram_pkg::*;
#(
   parameter int DW           = 18,
   parameter bit FLOW_CAPABLE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pipe_sel,
   input  cmd_e          cmd_in,
   input  logic [DW-1:0] arr_data,
   output logic          drv,
   output logic [DW-1:0] out_data
);
   cmd_e          cmd_q;
   logic          hold_q;
   logic          pipe_drv_q;
   logic [DW-1:0] cap_q;
   logic          rd_live;

   assign rd_live = (cmd_q == CMD_READ);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q      <= CMD_DESEL;
         hold_q     <= 1'b0;
         pipe_drv_q <= 1'b0;
         cap_q      <= '0;
      end else begin
         cmd_q      <= cmd_in;
         hold_q     <= (cmd_in == CMD_DESEL) && rd_live;
         pipe_drv_q <= rd_live;
         if (rd_live) cap_q <= arr_data;
      end
   end

   if (FLOW_CAPABLE) begin : g_dual
      always_comb begin
         if (pipe_sel) begin
            drv      = pipe_drv_q;
            out_data = cap_q;
         end else begin
            drv      = rd_live | hold_q;
            out_data = rd_live ? arr_data : cap_q;
         end
      end
   end else begin : g_pipe_only
      assign drv      = pipe_drv_q;
      assign out_data = cap_q;
   end

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      $rose(rst_n) |-> !drv);

   // R6
   dcd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_in == CMD_DESEL && cmd_q == CMD_READ) |=> drv);
endmodule

// File: rtl/ssram_core.sv
`timescale 1ns/1ps
module ssram_core
   import ssram_pkg::*;
#(
   parameter int ADDR_W       = 6,
   parameter int LANES        = 2,
   parameter int LANE_W       = 9,
   parameter bit FLOW_CAPABLE = 1'b1,
   localparam int DW          = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pipe_sel,
   input  logic              cs,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DW-1:0]     wdata,
   input  logic              gwr,
   input  logic              bwe,
   input  logic [LANES-1:0]  lane_en,
   input  logic              oe,
   input  logic              sleep,
   output logic [DW-1:0]     rdata,
   output logic              rdata_vld
);
   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
      $error("ssram_core: ADDR_W out of range");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("ssram_core: LANES must be positive");
   end
   if (LANE_W < 1) begin : g_bad_lane_w
      $error("ssram_core: LANE_W must be positive");
   end

   cmd_e              cmd;
   logic [LANES-1:0]  wr_mask;
   logic [ADDR_W-1:0] addr_q;
   logic [DW-1:0]     arr_data;
   logic              drv_int;
   logic [DW-1:0]     out_data;
   logic              show;

   ssram_wr_decode #(.LANES(LANES)) u_dec (
      .cs      (cs),
      .sleep   (sleep),
      .gwr     (gwr),
      .bwe     (bwe),
      .lane_en (lane_en),
      .cmd     (cmd),
      .wr_mask (wr_mask)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) addr_q <= '0;
      else        addr_q <= addr;
   end

   ssram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
      .clk     (clk),
      .rst_n   (rst_n),
      .sleep_i (sleep),
      .wr_addr (addr),
      .wr_data (wdata),
      .wr_mask (wr_mask),
      .rd_addr (addr_q),
      .rd_data (arr_data)
   );

   ssram_out_stage #(.DW(DW), .FLOW_CAPABLE(FLOW_CAPABLE)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .pipe_sel (pipe_sel),
      .cmd_in   (cmd),
      .arr_data (arr_data),
      .drv      (drv_int),
      .out_data (out_data)
   );

   assign show      = oe & ~sleep & drv_int;
   assign rdata_vld = show;
   assign rdata     = show ? out_data : '0;

   // R4
   gw_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && !sleep && gwr) |-> (&wr_mask));

   // R2
   flow_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pipe_sel && cmd == CMD_READ) |=> (drv_int || pipe_sel));

   // R3
   pipe_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pipe_sel && cmd == CMD_READ) |=> ##1 (drv_int || !pipe_sel));

   // R8
   always_comb begin
      if (rst_n && !oe) oe_off_chk: assert (rdata == '0);
   end
endmodule

// File: tb/ssram_core_bench.sv
`timescale 1ns/1ps
module ssram_core_bench;
   localparam int AW    = 6;
   localparam int LN    = 2;
   localparam int LW    = 9;
   localparam int DW    = LN * LW;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pipe_sel = 1'b0;
   logic          cs = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic          gwr = 1'b0;
   logic          bwe = 1'b0;
   logic [LN-1:0] lane_en = '0;
   logic          oe = 1'b1;
   logic          sleep = 1'b0;
   logic [DW-1:0] rdata;
   logic          rdata_vld;

   int total = 0;
   int bad   = 0;

   // reference model state: 0 deselect, 1 read, 2 write
   logic [DW-1:0] mdl [DEPTH];
   int            c1 = 0;
   int            c2 = 0;
   logic [AW-1:0] a1 = '0;
   logic [DW-1:0] cap = '0;
   string         cur_tag = "R1";

   always #2 clk = ~clk;

   ssram_core #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) u_ssram_core (
      .clk(clk), .rst_n(rst_n), .pipe_sel(pipe_sel), .cs(cs), .addr(addr),
      .wdata(wdata), .gwr(gwr), .bwe(bwe), .lane_en(lane_en), .oe(oe),
      .sleep(sleep), .rdata(rdata), .rdata_vld(rdata_vld)
   );

   function automatic int cmd_of(logic c, logic s, logic g, logic b, logic [LN-1:0] le);
      if (!c || s) return 0;
      if (g || (b && (le != '0))) return 2;
      return 1;
   endfunction

   function automatic logic exp_drv();
      if (pipe_sel) return c2 == 1;
      return (c1 == 1) || (c1 == 0 && c2 == 1);
   endfunction

   function automatic logic [DW-1:0] exp_word();
      if (!pipe_sel && c1 == 1) return mdl[a1];
      return cap;
   endfunction

   task automatic chk(input string tag, input logic [DW:0] act, input logic [DW:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare(input string tag);
      logic          ev;
      logic [DW-1:0] ed;
      ev = oe & ~sleep & exp_drv();
      ed = ev ? exp_word() : '0;
      chk(tag, {rdata_vld, rdata}, {ev, ed});
   endtask

   task automatic mdl_edge();
      int n;
      n = cmd_of(cs, sleep, gwr, bwe, lane_en);
      if (c1 == 1) cap = mdl[a1];
      if (n == 2) begin
         for (int l = 0; l < LN; l++) begin
            if (gwr || lane_en[l]) mdl[addr][l*LW +: LW] = wdata[l*LW +: LW];
         end
      end
      c2 = c1;
      c1 = n;
      a1 = addr;
   endtask

   task automatic cyc(input logic i_cs, input logic [AW-1:0] i_a, input logic [DW-1:0] i_d,
                      input logic i_g, input logic i_b, input logic [LN-1:0] i_le);
      cs = i_cs; addr = i_a; wdata = i_d; gwr = i_g; bwe = i_b; lane_en = i_le;
      @(posedge clk);
      mdl_edge();
      @(negedge clk);
      compare(cur_tag);
   endtask

   task automatic rd(input logic [AW-1:0] a);
      cyc(1'b1, a, '0, 1'b0, 1'b0, '0);
   endtask

   task automatic idle();
      cyc(1'b0, '0, '0, 1'b0, 1'b0, '0);
   endtask

   initial begin
      #800000;
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd1357));
      for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1", {rdata_vld, rdata}, '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", {rdata_vld, rdata}, '0);

      // fill through global writes (flow mode)
      cur_tag = "R4";
      for (int i = 0; i < DEPTH; i++)
         cyc(1'b1, AW'(i), DW'($urandom), 1'b1, 1'b0, '0);

      // R4: global write overrides byte controls
      cyc(1'b1, 6'd5, 18'h2A5A5, 1'b1, 1'b1, 2'b00);
      rd(6'd5);
      chk("R4", {rdata_vld, rdata}, {1'b1, 18'h2A5A5});

      // R5: lane 0 only, then non-writes
      cur_tag = "R5";
      cyc(1'b1, 6'd5, 18'h00133, 1'b0, 1'b1, 2'b01);
      rd(6'd5);
      chk("R5", {rdata_vld, rdata}, {1'b1, 18'h2A533});
      cyc(1'b1, 6'd5, 18'h3FFFF, 1'b0, 1'b1, 2'b00);
      chk("R5", {rdata_vld, rdata}, {1'b1, 18'h2A533});
      cyc(1'b1, 6'd5, 18'h3FFFF, 1'b0, 1'b0, 2'b11);
      chk("R5", {rdata_vld, rdata}, {1'b1, 18'h2A533});
      cyc(1'b1, 6'd5, 18'h3FE00, 1'b0, 1'b1, 2'b10);
      rd(6'd5);
      chk("R5", {rdata_vld, rdata}, {1'b1, 18'h3FF33});

      // R2: flow latency
      cur_tag = "R2";
      cyc(1'b1, 6'd9, 18'h12345, 1'b1, 1'b0, '0);
      idle();
      rd(6'd9);
      chk("R2", {rdata_vld, rdata}, {1'b1, 18'h12345});

      // R6: flow deselect hold
      cur_tag = "R6";
      idle();
      chk("R6", {rdata_vld, rdata}, {1'b1, 18'h12345});
      idle();
      chk("R6", {rdata_vld, rdata}, '0);

      // R7: write slot in flow mode
      cur_tag = "R7";
      rd(6'd9);
      cyc(1'b1, 6'd10, 18'h0BEEF, 1'b1, 1'b0, '0);
      chk("R7", {rdata_vld, rdata}, '0);
      idle(); idle();

      // R3 and R6 in pipelined mode
      pipe_sel = 1'b1;
      cur_tag = "R3";
      idle();
      rd(6'd10);
      chk("R3", {rdata_vld, rdata}, '0);
      idle();
      chk("R3", {rdata_vld, rdata}, {1'b1, 18'h0BEEF});
      cur_tag = "R6";
      idle();
      chk("R6", {rdata_vld, rdata}, '0);
      rd(6'd9);
      rd(6'd10);
      idle();
      chk("R6", {rdata_vld, rdata}, {1'b1, 18'h0BEEF});
      idle();
      chk("R6", {rdata_vld, rdata}, '0);
      cur_tag = "R7";
      rd(6'd9);
      cyc(1'b1, 6'd11, 18'h00777, 1'b1, 1'b0, '0);
      chk("R7", {rdata_vld, rdata}, {1'b1, 18'h12345});
      idle();
      chk("R7", {rdata_vld, rdata}, '0);
      idle(); idle();

      // R8: asynchronous output enable
      pipe_sel = 1'b0;
      cur_tag = "R8";
      idle();
      rd(6'd9);
      #0.4 oe = 1'b0;
      #0.4 chk("R8", {rdata_vld, rdata}, '0);
      oe = 1'b1;
      #0.4 chk("R8", {rdata_vld, rdata}, {1'b1, 18'h12345});

      // R9: asynchronous sleep, blocked writes, retention
      cur_tag = "R9";
      rd(6'd9);
      #0.4 sleep = 1'b1;
      #0.4 chk("R9", {rdata_vld, rdata}, '0);
      cyc(1'b1, 6'd9, 18'h3C3C3, 1'b1, 1'b0, '0);
      cyc(1'b1, 6'd9, 18'h3C3C3, 1'b0, 1'b1, 2'b11);
      chk("R9", {rdata_vld, rdata}, '0);
      sleep = 1'b0;
      idle();
      rd(6'd9);
      chk("R9", {rdata_vld, rdata}, {1'b1, 18'h12345});
      idle(); idle();

      // random traffic in both modes
      for (int m = 0; m < 2; m++) begin
         pipe_sel = (m == 1);
         cur_tag  = (m == 1) ? "R3" : "R2";
         idle(); idle();
         for (int i = 0; i < 1500; i++) begin
            oe    = ($urandom % 8) != 0;
            sleep = ($urandom % 16) == 0;
            cyc(($urandom % 6) != 0, AW'($urandom % 8), DW'($urandom),
                ($urandom % 6) == 0, ($urandom % 3) == 0, LN'($urandom));
         end
         oe = 1'b1; sleep = 1'b0;
         idle(); idle();
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule